// File: doc/BRIEF.md
# Converter Sample to Stream Bridge

This block brings samples from a slow external data converter into a fast system clock domain and hands them downstream over a valid/ready stream. The converter's sample clock arrives from outside, asynchronous to the system clock and far slower than it. Inside the block it is used only as data. It passes through a short chain of flip-flops clocked by the system clock. A rising edge seen at the end of that chain becomes a one-cycle capture enable, so the design needs no derived or divided clock.

On each capture enable the sample is zero-extended into a wider output word and stored in a single holding register. The word is offered downstream with valid. Valid and the word stay unchanged until a transfer completes on a system clock edge at which valid and ready are both high. Every output comes straight from a register, and no output depends combinationally on ready.

If a capture arrives while the held word has not yet been taken, the new sample is discarded and a sticky overrun flag is raised. The converter's overflow indication is captured together with each accepted sample and accumulated into a second sticky flag. It is never placed in the data word.

Top module: `conv_stream_bridge`

## Requirements
- R1: Each rising edge of `conv_clk` leads to exactly one capture. If `conv_clk` changes between system clock edges, `out_valid` rises on the third following system clock edge when the holding register is empty.
- R2: The stored word carries the sample in bits 11:0. Bits 15:12 are zero.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R4: A transfer happens only on an edge where `out_valid` and `out_ready` are both high. After that edge `out_valid` is low, unless a capture lands on the same edge.
- R5: `out_valid` rises after a capture even while `out_ready` is held low.
- R6: A capture that arrives while an untaken word is held is dropped. The held word is kept, and `overrun_seen` goes high and stays high until reset.
- R7: When a capture lands on the same edge as a transfer, the new sample is loaded, `out_valid` stays high, and no overrun is flagged.
- R8: `ovf_seen` goes high when an accepted sample arrives with `conv_ovf` high, and stays high until reset. The `conv_ovf` value that comes with a dropped sample has no effect.
- R9: Synchronous active-high `rst` clears `out_valid`, both flags and the synchronizer. If `conv_clk` is already high when reset is released, no capture follows until `conv_clk` has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk | input | 1 | Asynchronous converter sample clock |
| conv_sample | input | 12 | Converter sample, stable around the rising edge of conv_clk |
| conv_ovf | input | 1 | Converter overflow indication belonging to the sample |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Held word is on offer |
| out_word | output | 16 | Zero-extended sample word |
| overrun_seen | output | 1 | Sticky flag: a sample was dropped |
| ovf_seen | output | 1 | Sticky flag: an accepted sample carried overflow |

## Verification
The two functions that can fall on the same system clock edge are the capture of a new sample and the completion of a transfer of the held word. The bench provokes this coincidence directly. It raises ready only on the edge where the capture is known to land, three edges after the sample clock rises. It then judges that the new word is on offer, that valid never dropped and that the overrun flag is still clear. The bench also runs random ready back-pressure against random sample clock timing. In that phase its reference model decides cycle by cycle whether each capture is loaded, dropped, or loaded alongside a transfer.

// File: rtl/conv_bridge_pkg.sv
package conv_bridge_pkg;
    localparam int unsigned DEF_SAMPLE_W    = 12;
    localparam int unsigned DEF_WORD_W      = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/conv_edge_sync.sv
module conv_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_en
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;
    localparam int unsigned FILL_W  = $clog2(CHAIN_W + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(CHAIN_W);

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic [FILL_W-1:0]  fill;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_in};
        if (st_q.fill != FILL_FULL) begin
            st_d.fill = st_q.fill + FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Edge is trusted only once every stage holds a real sample of the input.
    assign rise_en = (st_q.fill == FILL_FULL)
                   && st_q.chain[SYNC_STAGES-1]
                   && !st_q.chain[SYNC_STAGES];
endmodule

// File: rtl/conv_word_hold.sv
module conv_word_hold #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WORD_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                ovf_in,
    input  logic                take_ready,
    output logic                hold_valid,
    output logic [WORD_W-1:0]   hold_word,
    output logic                drop_flag,
    output logic                ovf_flag
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              drop;
        logic              ovf;
    } hold_t;

    hold_t st_d, st_q;
    logic  accept;

    always_comb begin
        accept = st_q.valid && take_ready;
        st_d   = st_q;
        if (accept) begin
            st_d.valid = 1'b0;
        end
        if (capture_en) begin
            if (!st_q.valid || accept) begin
                st_d.valid = 1'b1;
                st_d.word  = WORD_W'(sample_in);
                if (ovf_in) begin
                    st_d.ovf = 1'b1;
                end
            end else begin
                st_d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_valid = st_q.valid;
    assign hold_word  = st_q.word;
    assign drop_flag  = st_q.drop;
    assign ovf_flag   = st_q.ovf;
endmodule

// File: rtl/conv_stream_bridge.sv
module conv_stream_bridge
    import conv_bridge_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_clk,
    input  logic [SAMPLE_W-1:0] conv_sample,
    input  logic                conv_ovf,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word,
    output logic                overrun_seen,
    output logic                ovf_seen
);
    logic sample_en;

    conv_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (conv_clk),
        .rise_en  (sample_en)
    );

    conv_word_hold #(
        .SAMPLE_W(SAMPLE_W),
        .WORD_W  (WORD_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .capture_en (sample_en),
        .sample_in  (conv_sample),
        .ovf_in     (conv_ovf),
        .take_ready (out_ready),
        .hold_valid (out_valid),
        .hold_word  (out_word),
        .drop_flag  (overrun_seen),
        .ovf_flag   (ovf_seen)
    );
endmodule

// File: rtl/conv_stream_bridge_chk.sv
module conv_stream_bridge_chk #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WORD_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_en,
    input logic              out_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              overrun_seen,
    input logic              ovf_seen
);
    assert_single_en_R1: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_word >> SAMPLE_W) == '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !sample_en |=> !out_valid);

    assert_offer_R5: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> out_valid);

    assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
        sample_en && out_valid && !out_ready |=> overrun_seen && $stable(out_word));

    assert_sticky_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        overrun_seen |=> overrun_seen);

    assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_seen |=> ovf_seen);

    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sample_en);
endmodule

bind conv_stream_bridge conv_stream_bridge_chk #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_en    (sample_en),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .overrun_seen (overrun_seen),
    .ovf_seen     (ovf_seen)
);

// File: tb/conv_stream_bridge_test.sv
module conv_stream_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_clk = 1'b1;
    logic [11:0] conv_sample = '0;
    logic        conv_ovf = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        overrun_seen;
    logic        ovf_seen;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;

    // reference model state
    logic        mv = 1'b0;
    logic [15:0] mw = '0;
    logic        mover = 1'b0;
    logic        movf = 1'b0;
    int          cd = 0;

    always #2.5 clk = ~clk;

    conv_stream_bridge uut (
        .clk          (clk),
        .rst          (rst),
        .conv_clk     (conv_clk),
        .conv_sample  (conv_sample),
        .conv_ovf     (conv_ovf),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_word     (out_word),
        .overrun_seen (overrun_seen),
        .ovf_seen     (ovf_seen)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pad_word(input logic [11:0] s);
        return {4'b0000, s};
    endfunction

    // Drive after a falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic rdy, input logic slow, input logic [11:0] dat, input logic ov);
        logic en_now;
        logic hs;
        out_ready = rdy;
        if (slow && !conv_clk) cd = 3;
        conv_clk    = slow;
        conv_sample = dat;
        conv_ovf    = ov;
        @(posedge clk);
        en_now = (cd == 1);
        if (cd != 0) cd--;
        hs = mv && rdy;
        if (en_now) begin
            if (!mv || hs) begin
                mv = 1'b1;
                mw = pad_word(dat);
                if (ov) movf = 1'b1;
            end else begin
                mover = 1'b1;
            end
        end else if (hs) begin
            mv = 1'b0;
        end
        @(negedge clk);
        check("R4 valid", 32'(out_valid), 32'(mv));
        if (mv) check("R2 word", 32'(out_word), 32'(mw));
        check("R6 overrun", 32'(overrun_seen), 32'(mover));
        check("R8 ovf", 32'(ovf_seen), 32'(movf));
    endtask

    // One slow period: hi cycles high then lo cycles low; ready pattern chosen per cycle.
    task automatic slow_period(input int hi, input int lo, input logic [11:0] dat, input logic ov,
                               input int rdy_pct);
        for (int i = 0; i < hi; i++) step(($urandom % 100) < rdy_pct, 1'b1, dat, ov);
        for (int i = 0; i < lo; i++) step(($urandom % 100) < rdy_pct, 1'b0, dat ^ 12'hA5A, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // reset with the sample clock already high
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset valid", 32'(out_valid), 32'd0);
        check("R9 reset overrun", 32'(overrun_seen), 32'd0);
        check("R9 reset ovf", 32'(ovf_seen), 32'd0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 12'h111, 1'b0);
        check("R9 no capture from high level", 32'(out_valid), 32'd0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 12'h111, 1'b0);

        // R1 latency and R5 offer without ready
        step(1'b0, 1'b1, 12'h3C5, 1'b0);
        check("R1 not yet after 1", 32'(out_valid), 32'd0);
        step(1'b0, 1'b1, 12'h3C5, 1'b0);
        check("R1 not yet after 2", 32'(out_valid), 32'd0);
        step(1'b0, 1'b1, 12'h3C5, 1'b0);
        check("R1 valid after 3", 32'(out_valid), 32'd1);
        check("R5 valid with ready low", 32'(out_valid), 32'd1);
        check("R2 padded word", 32'(out_word), 32'h03C5);

        // R3 hold under back-pressure (slow clock goes low meanwhile, sample changes)
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 12'hFFF, 1'b1);
        check("R3 valid held", 32'(out_valid), 32'd1);
        check("R3 word held", 32'(out_word), 32'h03C5);

        // R7 capture on the same edge as a transfer
        step(1'b0, 1'b1, 12'h7E1, 1'b0);
        step(1'b0, 1'b1, 12'h7E1, 1'b0);
        step(1'b1, 1'b1, 12'h7E1, 1'b0);
        check("R7 valid stays", 32'(out_valid), 32'd1);
        check("R7 new word", 32'(out_word), 32'h07E1);
        check("R7 no overrun", 32'(overrun_seen), 32'd0);

        // R4 single transfer clears valid
        step(1'b1, 1'b1, 12'h7E1, 1'b0);
        check("R4 valid cleared", 32'(out_valid), 32'd0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 12'h000, 1'b0);

        // R6 and R8: pending word, second capture with ovf is dropped
        slow_period(4, 4, 12'h0AB, 1'b0, 0);
        check("R6 pending before drop", 32'(out_valid), 32'd1);
        slow_period(4, 4, 12'hBCD, 1'b1, 0);
        check("R6 overrun set", 32'(overrun_seen), 32'd1);
        check("R6 held word kept", 32'(out_word), 32'h00AB);
        check("R8 dropped ovf ignored", 32'(ovf_seen), 32'd0);
        step(1'b1, 1'b0, 12'h000, 1'b0);
        slow_period(4, 4, 12'h456, 1'b1, 0);
        check("R8 ovf captured", 32'(ovf_seen), 32'd1);
        check("R8 ovf not in word", 32'(out_word), 32'h0456);
        check("R6 overrun sticky", 32'(overrun_seen), 32'd1);

        // random timing and back-pressure
        for (int p = 0; p < 300; p++) begin
            slow_period(3 + int'($urandom % 6), 3 + int'($urandom % 6),
                        12'($urandom), 1'($urandom % 2), (p < 150) ? 70 : 10);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule